// File: doc/BRIEF.md
# Dual-Level PWM LED Channel Controller

This block turns a set of per-channel brightness values and a shared group setting into on/off enables for the two output transistors of each LED pin. Each clock edge is one base tick, nominally 40 ns. Every channel has a fast brightness PWM whose period is 2^DW ticks. A slower shared group envelope can gate that PWM. In dimming mode the envelope steps once every 2 × 2^DW ticks. In blinking mode each step lasts (F+1) × BLINK_STEP ticks. The envelope has 2^DW steps per period, and it is active for the first M of them.

A 2-bit source selector per channel picks one of four signals: off, fully on, the channel's own PWM, or that PWM ANDed with the group envelope. A shared inversion bit acts on the chosen level. A drive-style bit then turns the level into enables for the transistor that pulls the pin to supply (`drv_hi_o`) and the one that pulls it to ground (`drv_lo_o`). When the active-low output enable is released, a 2-bit idle selector forces every pin and overrides the source selectors. All channels share one tick counter and one envelope counter, so they stay phase-aligned.

Top module: `dual_pwm_led_ctrl`

## Requirements
- R1: A synchronous reset clears all counters and drives every `drv_hi_o` and `drv_lo_o` bit to 0. The duty, group duty, blink frequency and group mode values present during reset are the ones used once reset is released.
- R2: Source code 10 (channel PWM) with inversion 0 in open-drain style sets the channel's low enable for the first N ticks of every 2^DW-tick period, where N is that channel's duty. N = 0 never sets it. Outputs are registered and reflect the state one clock after it is reached.
- R3: Group dimming (group mode 0) has a period of 2^DW × 2 × 2^DW ticks and is active for its first M × 2 × 2^DW ticks. Source code 11 ANDs the channel PWM with it, so M = 1 gives exactly two PWM pulses per group period and M = 4 gives eight.
- R4: Group blinking (group mode 1) makes each envelope step last (F+1) × BLINK_STEP ticks, with 2^DW steps per period and the first M steps active.
- R5: Source code 00 yields a logical level of 0 and code 01 yields a level of 1.
- R6: Open-drain style (`totem_i` = 0) never sets the high enable. A level of 1 (source XOR inversion) sets the low enable, and a level of 0 releases both transistors.
- R7: Totem-pole style (`totem_i` = 1) sets the low enable for a level of 1 and the high enable for a level of 0. The two enables of a channel are never set together in any style.
- R8: While `oe_n_i` = 1, every channel is forced by `idle_sel_i` and the source codes are ignored. Code 00 sets the low enable. Code 01 sets the high enable in totem-pole style and releases the pin in open-drain style. Codes 10 and 11 release the pin.
- R9: A new channel duty takes effect only at the start of the next channel PWM period. New group duty, blink frequency and group mode values take effect only at the start of the next group period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | NCH*DW | Channel duties; channel k uses bits [k*DW +: DW] |
| src_sel_i | input | 2*NCH | Source codes; channel k uses bits [2k +: 2] |
| grp_duty_i | input | DW | Group envelope duty M |
| blink_freq_i | input | DW | Blink step multiplier F |
| blink_mode_i | input | 1 | 0 = group dimming, 1 = group blinking |
| invert_i | input | 1 | Inverts the selected level |
| totem_i | input | 1 | 0 = open-drain style, 1 = totem-pole style |
| oe_n_i | input | 1 | Output enable, active low |
| idle_sel_i | input | 2 | Pin state while outputs are disabled |
| drv_hi_o | output | NCH | Pull-to-supply transistor enables |
| drv_lo_o | output | NCH | Pull-to-ground transistor enables |

## Verification
The hardest behaviour to reach from the ports is the deferred loading of group settings. A new group duty or blink frequency must do nothing until the envelope counter wraps, and with the default widths that happens only after many thousands of ticks. The bench shrinks DW to 4 and BLINK_STEP to 3, so a full group period fits in a few hundred clocks. It then changes settings in the middle of both periods and counts PWM pulses over whole group periods. A tick-level reference model, compared on every clock, flags any early or late take-up.

// File: rtl/ledpwm_pkg.sv
package ledpwm_pkg;

   typedef enum logic [1:0] {
      SRC_OFF   = 2'b00,
      SRC_ON    = 2'b01,
      SRC_CHAN  = 2'b10,
      SRC_GATED = 2'b11
   } src_sel_e;

   typedef enum logic [1:0] {
      IDLE_LOW  = 2'b00,
      IDLE_HIGH = 2'b01,
      IDLE_HZ_A = 2'b10,
      IDLE_HZ_B = 2'b11
   } idle_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } drv_pair_t;

   // Map a logical level onto the two transistor enables.
   function automatic drv_pair_t level_to_drive(input logic level, input logic totem);
      drv_pair_t d;
      d.lo = level;
      d.hi = totem & ~level;
      return d;
   endfunction

   // Forced pin state while the outputs are disabled.
   function automatic drv_pair_t idle_drive(input logic [1:0] sel, input logic totem);
      drv_pair_t d;
      case (idle_e'(sel))
         IDLE_LOW:  begin d.hi = 1'b0;  d.lo = 1'b1; end
         IDLE_HIGH: begin d.hi = totem; d.lo = 1'b0; end
         default:   begin d.hi = 1'b0;  d.lo = 1'b0; end
      endcase
      return d;
   endfunction

endpackage

// File: rtl/fast_tick_counter.sv
module fast_tick_counter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   output logic [DW-1:0] tick_o,
   output logic          wrap_o
);
   localparam logic [DW-1:0] LAST = {DW{1'b1}};

   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = cnt_q;
   assign wrap_o = (cnt_q == LAST);
endmodule

// File: rtl/group_envelope.sv
module group_envelope #(
   parameter int          DW         = 8,
   parameter int unsigned BLINK_STEP = 4069
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] grp_duty_i,
   input  logic [DW-1:0] blink_freq_i,
   input  logic          blink_mode_i,
   output logic          active_o
);
   localparam int unsigned STEPS     = 1 << DW;
   localparam int unsigned DIM_STEP  = 2 * STEPS;
   localparam int unsigned BLINK_MAX = STEPS * BLINK_STEP;
   localparam int unsigned MAX_LIM   = (DIM_STEP > BLINK_MAX) ? DIM_STEP : BLINK_MAX;
   localparam int          PW        = $clog2(MAX_LIM + 1);
   localparam logic [DW-1:0] LAST    = {DW{1'b1}};

   logic [PW-1:0] presc_q;
   logic [PW-1:0] limit;
   logic [DW-1:0] phase_q;
   logic [DW-1:0] m_q;
   logic [DW-1:0] f_q;
   logic          blink_q;
   logic          step_end;

   always_comb begin
      if (blink_q) limit = (PW'(f_q) + PW'(1)) * PW'(BLINK_STEP);
      else         limit = PW'(DIM_STEP);
   end

   assign step_end = (presc_q == limit - PW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         presc_q <= '0;
         phase_q <= '0;
         m_q     <= grp_duty_i;
         f_q     <= blink_freq_i;
         blink_q <= blink_mode_i;
      end else if (step_end) begin
         presc_q <= '0;
         phase_q <= phase_q + 1'b1;
         if (phase_q == LAST) begin
            m_q     <= grp_duty_i;
            f_q     <= blink_freq_i;
            blink_q <= blink_mode_i;
         end
      end else begin
         presc_q <= presc_q + PW'(1);
      end
   end

   assign active_o = (phase_q < m_q);
endmodule

// File: rtl/led_lane.sv
module led_lane
   import ledpwm_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] duty_i,
   input  logic [DW-1:0] tick_i,
   input  logic          wrap_i,
   input  logic          grp_active_i,
   input  logic [1:0]    sel_i,
   input  logic          invert_i,
   input  logic          totem_i,
   input  logic          oe_n_i,
   input  logic [1:0]    idle_sel_i,
   output logic          hi_o,
   output logic          lo_o
);
   logic [DW-1:0] duty_q;
   logic          chan_on;
   logic          src;
   drv_pair_t     nxt;
   drv_pair_t     drv_q;

   always_ff @(posedge clk) begin
      if (rst || wrap_i) duty_q <= duty_i;
   end

   assign chan_on = (tick_i < duty_q);

   always_comb begin
      case (src_sel_e'(sel_i))
         SRC_OFF:  src = 1'b0;
         SRC_ON:   src = 1'b1;
         SRC_CHAN: src = chan_on;
         default:  src = chan_on & grp_active_i;
      endcase
      if (oe_n_i) nxt = idle_drive(idle_sel_i, totem_i);
      else        nxt = level_to_drive(src ^ invert_i, totem_i);
   end

   always_ff @(posedge clk) begin
      if (rst) drv_q <= '0;
      else     drv_q <= nxt;
   end

   assign hi_o = drv_q.hi;
   assign lo_o = drv_q.lo;
endmodule

// File: rtl/dual_pwm_led_ctrl.sv
module dual_pwm_led_ctrl #(
   parameter int          NCH        = 4,
   parameter int          DW         = 8,
   parameter int unsigned BLINK_STEP = 4069
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NCH*DW-1:0] duty_i,
   input  logic [2*NCH-1:0]  src_sel_i,
   input  logic [DW-1:0]     grp_duty_i,
   input  logic [DW-1:0]     blink_freq_i,
   input  logic              blink_mode_i,
   input  logic              invert_i,
   input  logic              totem_i,
   input  logic              oe_n_i,
   input  logic [1:0]        idle_sel_i,
   output logic [NCH-1:0]    drv_hi_o,
   output logic [NCH-1:0]    drv_lo_o
);
   generate
      if (NCH < 1 || NCH > 64) begin : g_bad_nch
         $error("NCH out of range");
      end
      if (DW < 2 || DW > 12) begin : g_bad_dw
         $error("DW out of range");
      end
      if (BLINK_STEP < 1) begin : g_bad_step
         $error("BLINK_STEP must be positive");
      end
   endgenerate

   logic [DW-1:0] tick;
   logic          wrap;
   logic          grp_active;

   fast_tick_counter #(.DW(DW)) u_tick (
      .clk(clk), .rst(rst), .tick_o(tick), .wrap_o(wrap)
   );

   group_envelope #(.DW(DW), .BLINK_STEP(BLINK_STEP)) u_grp (
      .clk(clk), .rst(rst),
      .grp_duty_i(grp_duty_i), .blink_freq_i(blink_freq_i),
      .blink_mode_i(blink_mode_i), .active_o(grp_active)
   );

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_lane
         led_lane #(.DW(DW)) u_lane (
            .clk(clk), .rst(rst),
            .duty_i(duty_i[k*DW +: DW]),
            .tick_i(tick), .wrap_i(wrap),
            .grp_active_i(grp_active),
            .sel_i(src_sel_i[2*k +: 2]),
            .invert_i(invert_i), .totem_i(totem_i),
            .oe_n_i(oe_n_i), .idle_sel_i(idle_sel_i),
            .hi_o(drv_hi_o[k]), .lo_o(drv_lo_o[k])
         );
      end
   endgenerate
endmodule

// File: rtl/dual_pwm_led_ctrl_chk.sv
module dual_pwm_led_ctrl_chk #(
   parameter int NCH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [2*NCH-1:0] src_sel_i,
   input logic             invert_i,
   input logic             totem_i,
   input logic             oe_n_i,
   input logic [1:0]       idle_sel_i,
   input logic [NCH-1:0]   drv_hi_o,
   input logic [NCH-1:0]   drv_lo_o
);
   logic seen_rst = 1'b0;

   always @(posedge clk) begin
      // R1
      if (seen_rst) begin
         reset_off_chk: assert (drv_hi_o == '0 && drv_lo_o == '0)
            else $error("outputs not cleared by reset");
      end
      seen_rst <= rst;
   end

   // R7
   never_both_chk: assert property (@(posedge clk) disable iff (rst)
      (drv_hi_o & drv_lo_o) == '0);

   // R6
   od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!totem_i) |-> drv_hi_o == '0);

   // R8
   idle_low_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && oe_n_i && idle_sel_i == 2'b00) |-> (drv_lo_o == {NCH{1'b1}} && drv_hi_o == '0));

   // R8
   idle_hz_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && oe_n_i && idle_sel_i[1]) |-> (drv_lo_o == '0 && drv_hi_o == '0));

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         // R5
         full_on_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && !oe_n_i && !invert_i && src_sel_i[2*k +: 2] == 2'b01) |-> drv_lo_o[k]);
      end
   endgenerate
endmodule

bind dual_pwm_led_ctrl dual_pwm_led_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst(rst), .src_sel_i(src_sel_i), .invert_i(invert_i),
   .totem_i(totem_i), .oe_n_i(oe_n_i), .idle_sel_i(idle_sel_i),
   .drv_hi_o(drv_hi_o), .drv_lo_o(drv_lo_o)
);

// File: tb/sim_dual_pwm_led_ctrl.sv
`timescale 1ns/1ps
module sim_dual_pwm_led_ctrl;
   localparam int NCH = 4;
   localparam int DW  = 4;
   localparam int BS  = 3;
   localparam int P   = 1 << DW;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH*DW-1:0] duty = '0;
   logic [2*NCH-1:0]  sel = '0;
   logic [DW-1:0]     gduty = '0;
   logic [DW-1:0]     bfreq = '0;
   logic              bmode = 1'b0;
   logic              inv = 1'b0;
   logic              totem = 1'b0;
   logic              oe_n = 1'b0;
   logic [1:0]        idle = 2'b00;
   logic [NCH-1:0]    hi, lo;

   dual_pwm_led_ctrl #(.NCH(NCH), .DW(DW), .BLINK_STEP(BS)) u0 (
      .clk(clk), .rst(rst), .duty_i(duty), .src_sel_i(sel),
      .grp_duty_i(gduty), .blink_freq_i(bfreq), .blink_mode_i(bmode),
      .invert_i(inv), .totem_i(totem), .oe_n_i(oe_n), .idle_sel_i(idle),
      .drv_hi_o(hi), .drv_lo_o(lo)
   );

   always #2.5 clk = ~clk;

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   string cur_req = "R1";

   // reference model state
   int pc, pr, gp, ml, fl, gml, lim;
   int dl[NCH];
   logic [NCH-1:0] eh = '0, el = '0;

   always @(posedge clk) begin
      if (rst) begin
         pc = 0; pr = 0; gp = 0;
         for (int i = 0; i < NCH; i++) dl[i] = int'(duty[i*DW +: DW]);
         ml = int'(gduty); fl = int'(bfreq); gml = int'(bmode);
         eh = '0; el = '0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            bit ion, src, lvl;
            int m;
            ion = (pc < dl[i]);
            m = int'(sel[2*i +: 2]);
            if (m == 0)      src = 0;
            else if (m == 1) src = 1;
            else if (m == 2) src = ion;
            else             src = ion && (gp < ml);
            lvl = src ^ inv;
            if (oe_n) begin
               el[i] = (idle == 2'b00);
               eh[i] = (idle == 2'b01) && totem;
            end else begin
               el[i] = lvl;
               eh[i] = totem && !lvl;
            end
         end
         lim = gml ? (fl + 1) * BS : 2 * P;
         if (pc == P - 1)
            for (int i = 0; i < NCH; i++) dl[i] = int'(duty[i*DW +: DW]);
         pc = (pc + 1) % P;
         if (pr == lim - 1) begin
            pr = 0;
            if (gp == P - 1) begin
               ml = int'(gduty); fl = int'(bfreq); gml = int'(bmode);
            end
            gp = (gp + 1) % P;
         end else pr = pr + 1;
      end
   end

   // per-clock comparison and pulse counting, away from the active edge
   logic           cmp_en = 1'b0;
   logic           cnt_en = 1'b0;
   logic           prev_lo0 = 1'b0;
   int             rises = 0;

   always @(negedge clk) begin
      if (cmp_en) begin
         checks++;
         if (hi !== eh || lo !== el) begin
            fails++;
            $display("FAIL %s cyc=%0d hi/lo actual=%b/%b expected=%b/%b",
                     cur_req, cyc, hi, lo, eh, el);
         end
      end
      if (cnt_en && lo[0] && !prev_lo0) rises++;
      prev_lo0 = lo[0];
   end

   task automatic finish_sim();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
         finish_sim();
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_eq(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic set_duty(int a, int b, int c, int d);
      duty = {DW'(d), DW'(c), DW'(b), DW'(a)};
   endtask

   task automatic count_pulses(string req, int window, int expv);
      @(negedge clk);
      rises = 0;
      prev_lo0 = lo[0];
      cnt_en = 1'b1;
      run(window);
      cnt_en = 1'b0;
      check_eq(req, rises, expv);
   endtask

   initial begin
      // R1: reset, with settings loaded while held
      set_duty(3, 7, 0, 15);
      gduty = 4'd2;
      sel = 8'b11_10_01_00;
      @(negedge clk);
      cmp_en = 1'b1;
      run(4);
      check_eq("R1", int'(hi), 0);
      check_eq("R1", int'(lo), 0);
      rst = 1'b0;
      run(3);

      // R5: off / full on sources
      cur_req = "R5";
      sel = 8'b01_00_01_00;
      run(40);

      // R2: individual PWM, several duties including 0 and max
      cur_req = "R2";
      sel = 8'b10_10_10_10;
      set_duty(0, 3, 8, 15);
      run(70);

      // R6: open-drain, inverted
      cur_req = "R6";
      inv = 1'b1;
      run(40);
      sel = 8'b01_00_10_11;
      run(40);

      // R7: totem-pole, both polarities
      cur_req = "R7";
      totem = 1'b1;
      run(40);
      inv = 1'b0;
      sel = 8'b10_01_00_10;
      run(40);
      totem = 1'b0;

      // R9: duty change in the middle of a period
      cur_req = "R9";
      sel = 8'b10_10_10_10;
      run(5);
      set_duty(12, 1, 6, 9);
      run(40);
      sel = 8'b11_11_11_11;
      gduty = 4'd9;
      run(300);
      gduty = 4'd3;
      run(700);

      // R3: group dimming, pulse counting over whole group periods
      cur_req = "R3";
      set_duty(5, 5, 5, 5);
      gduty = 4'd1;
      run(2 * P * 2 * P + 20);
      count_pulses("R3", 2 * P * 2 * P, 4);
      gduty = 4'd4;
      run(2 * P * 2 * P + 20);
      count_pulses("R3", 2 * P * 2 * P, 16);

      // R4: blinking at two frequencies
      cur_req = "R4";
      bmode = 1'b1;
      bfreq = 4'd2;
      gduty = 4'd5;
      run(1200);
      bfreq = 4'd0;
      gduty = 4'd11;
      run(1600);
      bmode = 1'b0;
      run(1800);

      // R8: output disable, every idle code, both drive styles
      cur_req = "R8";
      oe_n = 1'b1;
      sel = 8'b01_00_10_11;
      for (int t = 0; t < 2; t++) begin
         totem = t[0];
         for (int c = 0; c < 4; c++) begin
            idle = c[1:0];
            run(12);
         end
      end
      idle = 2'b01;
      totem = 1'b0;
      run(3);
      check_eq("R8", int'(hi), 0);
      check_eq("R8", int'(lo), 0);
      oe_n = 1'b0;
      run(20);

      cmp_en = 1'b0;
      run(2);
      finish_sim();
   end
endmodule